// File: doc/BRIEF.md
# I2C Slave Address Recogniser

This block decides whether an I2C transfer is meant for this device. After every start or repeated start it examines the first received byte. It compares the upper seven bits with two programmable slave addresses and also checks the byte for the general call value. It then reports which address matched and drives the acknowledge decision for the ninth clock. It also reports whether the master asked the slave to transmit.

A three-bit format code selects which addresses take part. The code is built from a switch input and the low bit of each address register. The same code can also bypass addressing completely, which gives a formatless mode where every frame is acknowledged. The block does no shifting and generates no clock. A neighbouring shifter supplies the received byte, a strobe when each byte is complete, and pulses when start and stop conditions are detected. Every output is registered and changes on the clock edge that samples a strobe.

Top module: `i2c_addr_recog`

## Requirements
- R1: After a synchronous reset all outputs are 0 (`match_a`, `match_b`, `match_gc`, `ack_drive`, `dir_tx`, `addressed`).
- R2: With format code {fmt_switch, own_addr_a[0], own_addr_b[0]} = 000, both addresses are active. If the first frame after a start has rx_byte[7:1] equal to own_addr_a[7:1], then `match_a`, `addressed` and `ack_drive` are 1 on the edge after the strobe. A match against own_addr_b[7:1] sets `match_b` in the same way.
- R3: Code 001 recognises only address A and code 010 recognises only address B. A first frame that carries the disabled address is not acknowledged.
- R4: Code 011, or any code with fmt_switch = 1, is formatless mode. Every frame strobe sets `ack_drive` = 1, while all match flags, `dir_tx` and `addressed` stay 0.
- R5: In an addressed format, a first frame equal to 8'h00 sets `match_gc` and is acknowledged. A first frame of 8'h01 is not a general call. At most one match flag is ever set, and the priority is A, then B, then general call.
- R6: On a match of address A or B, `dir_tx` takes rx_byte[0], where 1 means the slave transmits. For later frames of the same transfer, `ack_drive` is 1 when receiving and 0 when transmitting. A general call never sets `dir_tx`.
- R7: A first frame that matches nothing gives `ack_drive` = 0. Later frames are ignored, with `ack_drive` and the flags kept at 0, until the next start.
- R8: Only the first frame after a start is compared with the addresses. A later frame that carries an own address changes no flag.
- R9: A start or repeated start clears all flags, `dir_tx`, `ack_drive` and `addressed`, and re-arms the comparison for the next frame.
- R10: A stop clears all outputs. In an addressed format, frames that arrive after a stop and before the next start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_seen | input | 1 | One-cycle pulse: start or repeated start detected |
| stop_seen | input | 1 | One-cycle pulse: stop detected |
| frame_strobe | input | 1 | One-cycle pulse: rx_byte holds a complete byte |
| rx_byte | input | ADDR_W+1 | Received byte; bit 0 is the direction bit |
| own_addr_a | input | ADDR_W+1 | Address A in bits 7..1, format bit in bit 0 |
| own_addr_b | input | ADDR_W+1 | Address B in bits 7..1, format bit in bit 0 |
| fmt_switch | input | 1 | Forces formatless mode when 1 |
| match_a | output | 1 | First frame matched address A |
| match_b | output | 1 | First frame matched address B |
| match_gc | output | 1 | First frame was the general call |
| ack_drive | output | 1 | 1 = pull SDA low on the ninth clock |
| dir_tx | output | 1 | Slave transmit requested |
| addressed | output | 1 | This device is selected for the current transfer |

## Verification
On every cycle the assertions check the following. The match flags are mutually exclusive. Start and stop clear the outputs. `dir_tx` is set only together with a slave-address match. The flags change only on a strobe, a start or a stop. Formatless frames are always acknowledged without selecting the device. Some behaviour can only be shown by the directed scenarios: which address wins under each format code, the A-over-B priority when both registers hold the same address, that later frames carrying an own address are ignored, and the acknowledge policy after a transmit-direction match.

// File: rtl/i2c_addr_recog_pkg.sv
package i2c_addr_recog_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SELECTED,
    ST_IGNORE
  } rcg_state_e;

  typedef enum logic [1:0] {
    FMT_BOTH,
    FMT_A_ONLY,
    FMT_B_ONLY,
    FMT_RAW
  } fmt_e;

  function automatic fmt_e decode_fmt(input logic sw, input logic sel_a, input logic sel_b);
    if (sw) return FMT_RAW;
    case ({sel_a, sel_b})
      2'b00:   return FMT_BOTH;
      2'b01:   return FMT_A_ONLY;
      2'b10:   return FMT_B_ONLY;
      default: return FMT_RAW;
    endcase
  endfunction

endpackage

// File: rtl/i2c_fmt_decode.sv
module i2c_fmt_decode
  import i2c_addr_recog_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic             fmt_switch,
  input  logic             sel_a,
  input  logic             sel_b,
  output logic [NSLOT-1:0] slot_en,
  output logic             gc_en,
  output logic             raw_mode
);
  fmt_e mode;

  always_comb begin
    mode     = decode_fmt(fmt_switch, sel_a, sel_b);
    slot_en  = '0;
    gc_en    = 1'b0;
    raw_mode = 1'b0;
    case (mode)
      FMT_BOTH:   begin slot_en[0] = 1'b1; slot_en[NSLOT-1] = 1'b1; gc_en = 1'b1; end
      FMT_A_ONLY: begin slot_en[0] = 1'b1; gc_en = 1'b1; end
      FMT_B_ONLY: begin slot_en[NSLOT-1] = 1'b1; gc_en = 1'b1; end
      default:    raw_mode = 1'b1;
    endcase
  end
endmodule

// File: rtl/i2c_slot_match.sv
module i2c_slot_match #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              enable,
  output logic              hit
);
  always_comb hit = enable && (rx_addr == slot_addr);
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_addr_recog_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_seen,
  input  logic            stop_seen,
  input  logic            frame_strobe,
  input  logic [ADDR_W:0] rx_byte,
  input  logic [ADDR_W:0] own_addr_a,
  input  logic [ADDR_W:0] own_addr_b,
  input  logic            fmt_switch,
  output logic            match_a,
  output logic            match_b,
  output logic            match_gc,
  output logic            ack_drive,
  output logic            dir_tx,
  output logic            addressed
);
  localparam int NSLOT  = 2;
  localparam int BYTE_W = ADDR_W + 1;

  logic [NSLOT-1:0]  slot_en;
  logic [NSLOT-1:0]  slot_hit;
  logic [ADDR_W-1:0] slot_addr [NSLOT];
  logic              gc_en;
  logic              raw_mode;
  logic              gc_hit;
  logic              win_a, win_b, win_gc, any_hit;
  rcg_state_e        state;

  assign slot_addr[0]       = own_addr_a[BYTE_W-1:1];
  assign slot_addr[NSLOT-1] = own_addr_b[BYTE_W-1:1];

  i2c_fmt_decode #(.NSLOT(NSLOT)) fmt_i (
    .fmt_switch (fmt_switch),
    .sel_a      (own_addr_a[0]),
    .sel_b      (own_addr_b[0]),
    .slot_en    (slot_en),
    .gc_en      (gc_en),
    .raw_mode   (raw_mode)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    i2c_slot_match #(.ADDR_W(ADDR_W)) cmp_i (
      .rx_addr   (rx_byte[BYTE_W-1:1]),
      .slot_addr (slot_addr[s]),
      .enable    (slot_en[s]),
      .hit       (slot_hit[s])
    );
  end

  // General call only with a zero direction bit; priority A > B > GC.
  always_comb begin
    gc_hit  = gc_en && (rx_byte == '0);
    win_a   = slot_hit[0];
    win_b   = slot_hit[NSLOT-1] && !slot_hit[0];
    win_gc  = gc_hit && !slot_hit[0] && !slot_hit[NSLOT-1];
    any_hit = win_a || win_b || win_gc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      match_a   <= 1'b0;
      match_b   <= 1'b0;
      match_gc  <= 1'b0;
      ack_drive <= 1'b0;
      dir_tx    <= 1'b0;
      addressed <= 1'b0;
    end else if (stop_seen || start_seen) begin
      state     <= stop_seen ? ST_IDLE : ST_ARMED;
      match_a   <= 1'b0;
      match_b   <= 1'b0;
      match_gc  <= 1'b0;
      ack_drive <= 1'b0;
      dir_tx    <= 1'b0;
      addressed <= 1'b0;
    end else if (frame_strobe) begin
      if (raw_mode) begin
        ack_drive <= 1'b1;
        match_a   <= 1'b0;
        match_b   <= 1'b0;
        match_gc  <= 1'b0;
        dir_tx    <= 1'b0;
        addressed <= 1'b0;
      end else begin
        case (state)
          ST_ARMED: begin
            match_a   <= win_a;
            match_b   <= win_b;
            match_gc  <= win_gc;
            ack_drive <= any_hit;
            addressed <= any_hit;
            dir_tx    <= rx_byte[0] && (win_a || win_b);
            state     <= any_hit ? ST_SELECTED : ST_IGNORE;
          end
          ST_SELECTED: ack_drive <= !dir_tx;
          default:     ack_drive <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_recog_chk.sv
module i2c_addr_recog_chk #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            start_seen,
  input logic            stop_seen,
  input logic            frame_strobe,
  input logic [ADDR_W:0] own_addr_a,
  input logic [ADDR_W:0] own_addr_b,
  input logic            fmt_switch,
  input logic            match_a,
  input logic            match_b,
  input logic            match_gc,
  input logic            ack_drive,
  input logic            dir_tx,
  input logic            addressed
);
  logic quiet, raw_cfg;
  assign quiet   = !start_seen && !stop_seen && !frame_strobe;
  assign raw_cfg = fmt_switch || (own_addr_a[0] && own_addr_b[0]);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({match_a, match_b, match_gc}));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> !(match_a || match_b || match_gc || dir_tx || addressed || ack_drive));

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !(match_a || match_b || match_gc || dir_tx || addressed || ack_drive));

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable({match_a, match_b, match_gc, dir_tx, addressed, ack_drive}));

  assert_dir_needs_slave_R6: assert property (@(posedge clk) disable iff (rst)
    dir_tx |-> (match_a || match_b));

  assert_raw_acks_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_strobe && !start_seen && !stop_seen && raw_cfg) |=>
      (ack_drive && !addressed && !match_a && !match_b && !match_gc));
endmodule

bind i2c_addr_recog i2c_addr_recog_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .start_seen   (start_seen),
  .stop_seen    (stop_seen),
  .frame_strobe (frame_strobe),
  .own_addr_a   (own_addr_a),
  .own_addr_b   (own_addr_b),
  .fmt_switch   (fmt_switch),
  .match_a      (match_a),
  .match_b      (match_b),
  .match_gc     (match_gc),
  .ack_drive    (ack_drive),
  .dir_tx       (dir_tx),
  .addressed    (addressed)
);

// File: tb/i2c_addr_recog_tb_top.sv
module i2c_addr_recog_tb_top;
  localparam logic [6:0] ADR_A = 7'h2A;
  localparam logic [6:0] ADR_B = 7'h51;
  // Expected vector order: {addressed, dir_tx, ack_drive, match_gc, match_b, match_a}
  localparam logic [5:0] V_NONE  = 6'b000000;
  localparam logic [5:0] V_A_RX  = 6'b101001;
  localparam logic [5:0] V_B_RX  = 6'b101010;
  localparam logic [5:0] V_B_TX  = 6'b111010;
  localparam logic [5:0] V_B_TXD = 6'b110010;
  localparam logic [5:0] V_GC    = 6'b101100;
  localparam logic [5:0] V_RAW   = 6'b001000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_seen = 1'b0, stop_seen = 1'b0, frame_strobe = 1'b0;
  logic [7:0] rx_byte = '0, own_addr_a = '0, own_addr_b = '0;
  logic       fmt_switch = 1'b0;
  logic       match_a, match_b, match_gc, ack_drive, dir_tx, addressed;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_recog #(.ADDR_W(7)) dut_i (
    .clk(clk), .rst(rst), .start_seen(start_seen), .stop_seen(stop_seen),
    .frame_strobe(frame_strobe), .rx_byte(rx_byte), .own_addr_a(own_addr_a),
    .own_addr_b(own_addr_b), .fmt_switch(fmt_switch), .match_a(match_a),
    .match_b(match_b), .match_gc(match_gc), .ack_drive(ack_drive),
    .dir_tx(dir_tx), .addressed(addressed)
  );

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {addressed, dir_tx, ack_drive, match_gc, match_b, match_a};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg(input logic fa, input logic fb, input logic sw);
    @(negedge clk);
    own_addr_a = {ADR_A, fa};
    own_addr_b = {ADR_B, fb};
    fmt_switch = sw;
  endtask

  task automatic do_start();
    @(negedge clk) start_seen = 1'b1;
    @(negedge clk) start_seen = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_seen = 1'b1;
    @(negedge clk) stop_seen = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin rx_byte = b; frame_strobe = 1'b1; end
    @(negedge clk) frame_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", V_NONE);
  endtask

  task automatic t_both();
    cfg(1'b0, 1'b0, 1'b0);
    do_start(); chk("R9 start clears", V_NONE);
    send({ADR_A, 1'b0}); chk("R2 match A", V_A_RX);
    send(8'h55); chk("R6 receive data acked", V_A_RX);
    send({ADR_B, 1'b0}); chk("R8 later frame not compared", V_A_RX);
    do_stop(); chk("R10 stop clears", V_NONE);
    do_start(); send({ADR_B, 1'b1}); chk("R2 match B transmit", V_B_TX);
    send(8'hC3); chk("R6 transmit data not acked", V_B_TXD);
    do_stop();
  endtask

  task automatic t_only_a();
    cfg(1'b0, 1'b1, 1'b0);
    do_start(); send({ADR_B, 1'b0}); chk("R3 B disabled in 001", V_NONE);
    send({ADR_A, 1'b0}); chk("R7 ignored after miss", V_NONE);
    do_start(); send({ADR_A, 1'b0}); chk("R3 A in 001", V_A_RX);
    do_stop();
  endtask

  task automatic t_only_b();
    cfg(1'b1, 1'b0, 1'b0);
    do_start(); send({ADR_A, 1'b0}); chk("R3 A disabled in 010", V_NONE);
    do_start(); send({ADR_B, 1'b0}); chk("R3 B in 010", V_B_RX);
    do_stop();
  endtask

  task automatic t_raw();
    cfg(1'b1, 1'b1, 1'b0);
    do_start(); send({ADR_A, 1'b0}); chk("R4 formatless 011", V_RAW);
    do_stop();
    cfg(1'b0, 1'b0, 1'b1);
    do_start(); send(8'h00); chk("R4 formatless switch", V_RAW);
    send(8'h9E); chk("R4 formatless later frame", V_RAW);
    do_stop();
  endtask

  task automatic t_gc();
    cfg(1'b0, 1'b0, 1'b0);
    do_start(); send(8'h00); chk("R5 general call", V_GC);
    send(8'h12); chk("R6 gc data acked", V_GC);
    do_start(); send(8'h01); chk("R5 0x01 not gc", V_NONE);
    do_stop();
  endtask

  task automatic t_priority();
    cfg(1'b0, 1'b0, 1'b0);
    @(negedge clk) own_addr_b = {ADR_A, 1'b0};
    do_start(); send({ADR_A, 1'b1}); chk("R5 A wins over B", 6'b111001);
    do_stop();
  endtask

  task automatic t_restart();
    cfg(1'b0, 1'b0, 1'b0);
    do_start(); send({ADR_A, 1'b0}); chk("R2 A before restart", V_A_RX);
    do_start(); chk("R9 repeated start clears", V_NONE);
    send({ADR_B, 1'b1}); chk("R9 new match after restart", V_B_TX);
    do_stop();
    send({ADR_A, 1'b0}); chk("R10 frame after stop ignored", V_NONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_both();
    t_only_a();
    t_only_b();
    t_raw();
    t_gc();
    t_priority();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule